// File: doc/BRIEF.md
# Buffered-Duty PWM Timer Channel

This block is one pulse-width-modulation timer channel. An external prescaler supplies a one-clock count-enable strobe. On each strobe the channel's counter moves forward through 1, 2, ... up to a programmed period value, and the next strobe takes it back to 1. The output pin is active while the count is at or below the active duty value and inactive above it. So a duty of zero keeps the pin low for a whole period, and a duty equal to or greater than the period keeps it high for a whole period.

Software never writes the active duty value directly. It writes a staging register, and the channel copies that value into the active duty at the period wrap: the strobe that moves the count from the period value back to 1. A change made partway through a period therefore first shows in the following period. The same wrap event sets a sticky wrap flag, which software clears by writing a one to it.

A small state machine sequences the channel through three states. IDLE means stopped: the counter and output are frozen. HOLD is the first full period after a start: the counter runs, but the pin keeps its retained level. RUN is the normal state, in which the pin follows the duty value. The transitions are:

- START_SEEN (IDLE to HOLD): the run bit is set; the counter is cleared so that the next strobe gives 1.
- FIRST_WRAP (HOLD to RUN): the first period wrap.
- STOPPED (HOLD or RUN to IDLE): the run bit is cleared.

Top module: `pwm_chan_top`

## Requirements
- R1: While started, each count-enable strobe advances the internal count 1, 2, ... up to the period register value, and the strobe after that returns it to 1. With no strobe the count does not change.
- R2: At the period wrap, the staging register is copied into the active duty. A staging write made partway through a period first affects the output in the next period.
- R3: Each period wrap sets the wrap flag (status register, address 3, bit 0). The flag stays set until software writes address 3 with bit 0 equal to 1.
- R4: With an active duty of 0, the output stays low for every count of the period.
- R5: With an active duty equal to or greater than the period value, the output stays high for every count of the period.
- R6: In RUN, the output is high exactly when the count lies between 1 and the active duty, inclusive.
- R7: For the first full period after a start (HOLD), the output keeps the level it had before the start. RUN begins at the first wrap.
- R8: Clearing the run bit (control register, address 2, bit 0) freezes the count and the output. A later start counts again from 1 and applies the R7 hold again.
- R9: If a flag-clear write and a period wrap fall in the same clock, the flag stays set.
- R10: After reset, every register reads 0 and the output is low.
- R11: Register map on the shared address: 0 is the period value, 1 is the staging duty, 2 is control (bit 0 is run), and 3 is status (bit 0 is the wrap flag). A read returns the stored value, with the unused bits of addresses 2 and 3 reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | One-clock count strobe from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pwm_out | output | 1 | PWM output pin, active high |

## Verification
The assertions assume that the count strobe lasts one clock and that the period value is at least 1. They also assume that the period register is not lowered below the current count while the channel runs. The stimulus keeps to these assumptions in three ways. It reprograms the period only while the channel is stopped. It keeps period values between 1 and 6. It pulses the strobe for one clock, with idle clocks between strobes. The sweep covers every duty from 0 to one past the period, so both the 0% and the 100% limits appear for each period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } pwm_state_e;

    localparam logic [1:0] ADDR_PERIOD = 2'd0;
    localparam logic [1:0] ADDR_STAGE  = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_STAT   = 2'd3;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int W  = 16,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          wrap,
    output logic [W-1:0]  period,
    output logic [W-1:0]  stage,
    output logic          run_bit,
    output logic          flag,
    output logic [W-1:0]  rd_data
);
    import pwm_pkg::*;

    logic clr_req;

    // A write of 1 to status bit 0 requests a flag clear.
    assign clr_req = wr_en && (wr_addr == AW'(ADDR_STAT)) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period  <= '0;
            stage   <= '0;
            run_bit <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADDR_PERIOD)) period  <= wr_data;
            if (wr_addr == AW'(ADDR_STAGE))  stage   <= wr_data;
            if (wr_addr == AW'(ADDR_CTRL))   run_bit <= wr_data[0];
        end
    end

    // A wrap in the same clock as a clear wins, so the flag stays set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (wrap)    flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            AW'(ADDR_PERIOD): rd_data = period;
            AW'(ADDR_STAGE):  rd_data = stage;
            AW'(ADDR_CTRL):   rd_data[0] = run_bit;
            default:          rd_data[0] = flag;
        endcase
    end
endmodule

// File: rtl/pwm_fsm.sv
module pwm_fsm (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_bit,
    input  logic              wrap,
    output pwm_pkg::pwm_state_e state,
    output logic              restart,
    output logic              counting,
    output logic              follow
);
    import pwm_pkg::*;

    pwm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_bit) state_d = ST_HOLD;   // START_SEEN
            ST_HOLD: if (!run_bit)  state_d = ST_IDLE; // STOPPED
                     else if (wrap) state_d = ST_RUN;  // FIRST_WRAP
            ST_RUN:  if (!run_bit)  state_d = ST_IDLE; // STOPPED
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        restart  = 1'b0;
        counting = 1'b0;
        follow   = 1'b0;
        unique case (state_q)
            ST_IDLE: restart  = run_bit;
            ST_HOLD: counting = 1'b1;
            ST_RUN:  begin
                counting = 1'b1;
                follow   = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         counting,
    input  logic         restart,
    input  logic         follow,
    input  logic [W-1:0] period,
    input  logic [W-1:0] stage,
    output logic         wrap,
    output logic [W-1:0] cnt,
    output logic [W-1:0] duty,
    output logic         pwm_out
);
    localparam logic [W-1:0] ONE = W'(1);

    logic held_q;
    logic level;

    // The wrap fires on the strobe that leaves the period value.
    assign wrap = counting && cnt_en && (cnt >= period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (restart)           cnt <= '0;
        else if (counting && cnt_en) cnt <= wrap ? ONE : cnt + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    duty <= '0;
        else if (wrap) duty <= stage;
    end

    assign level   = (cnt != '0) && (cnt <= duty);
    assign pwm_out = follow ? level : held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= pwm_out;
    end
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top #(
    parameter int W  = 16,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          pwm_out
);
    import pwm_pkg::*;

    logic [W-1:0] period, stage, cnt, duty;
    logic         run_bit, flag, wrap, restart, counting, follow;
    pwm_state_e   state;

    pwm_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .wrap(wrap),
        .period(period), .stage(stage), .run_bit(run_bit), .flag(flag),
        .rd_data(rd_data)
    );

    pwm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_bit(run_bit), .wrap(wrap),
        .state(state), .restart(restart), .counting(counting), .follow(follow)
    );

    pwm_gen #(.W(W)) u_gen (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .counting(counting),
        .restart(restart), .follow(follow), .period(period), .stage(stage),
        .wrap(wrap), .cnt(cnt), .duty(duty), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cnt_en,
    input logic                counting,
    input logic                wrap,
    input logic [W-1:0]        cnt,
    input logic [W-1:0]        period,
    input logic [W-1:0]        duty,
    input logic                flag,
    input logic                pwm_out,
    input pwm_pkg::pwm_state_e state
);
    import pwm_pkg::*;

    a_r1_wrap_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == W'(1)));

    a_r1_still_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && counting) |=> $stable(cnt));

    a_r2_duty_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty));

    a_r3_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);

    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && duty == '0) |-> !pwm_out);

    a_r5_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && duty >= period && cnt != '0 && cnt <= period) |-> pwm_out);

    a_r7_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && $past(state) != ST_RUN) |-> $stable(pwm_out));

    a_r8_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(cnt));
endmodule

bind pwm_chan_top pwm_chan_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .counting(counting),
    .wrap(wrap), .cnt(cnt), .period(period), .duty(duty), .flag(flag),
    .pwm_out(pwm_out), .state(state)
);

// File: tb/pwm_chan_top_tb.sv
`timescale 1ns/100ps
module pwm_chan_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model: 0 = stopped, 1 = hold period, 2 = running.
    int mstate = 0;
    int mcnt = 0;
    int mcyc = 0;
    int mduty = 0;
    int mbuf = 0;
    bit mheld = 0;

    pwm_chan_top u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd1) mbuf = d;
        if (a == 2'd0) mcyc = d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic start_ch();
        wr(2'd2, 16'd1);
        @(negedge clk);
        mstate = 1; mcnt = 0;
    endtask

    task automatic stop_ch();
        wr(2'd2, 16'd0);
        @(negedge clk);
        mstate = 0;
    endtask

    function automatic bit exp_out();
        if (mstate == 2) return (mcnt >= 1 && mcnt <= mduty);
        return mheld;
    endfunction

    // One strobe; the model advances and the output is compared.
    task automatic tick(input string req);
        @(negedge clk) cnt_en = 1'b1;
        @(negedge clk) cnt_en = 1'b0;
        #1;
        if (mstate != 0) begin
            if (mcnt >= mcyc) begin
                mcnt = 1; mduty = mbuf;
                if (mstate == 1) mstate = 2;
            end else mcnt++;
        end
        chk(pwm_out == exp_out(), req, pwm_out, exp_out());
        mheld = exp_out();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        #1;
        chk(pwm_out == 1'b0, "R10 output", pwm_out, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 16'd0, "R10 register reset", v, 0);
        end
        rst_n = 1'b1;

        // R11 register map readback
        wr(2'd0, 16'hA5C3); wr(2'd1, 16'h1234); wr(2'd2, 16'hFFFF);
        rd(2'd0, v); chk(v == 16'hA5C3, "R11 period", v, 16'hA5C3);
        rd(2'd1, v); chk(v == 16'h1234, "R11 stage", v, 16'h1234);
        rd(2'd2, v); chk(v == 16'd1, "R11 control", v, 1);
        stop_ch();
        rd(2'd2, v); chk(v == 16'd0, "R11 control clear", v, 0);

        // Sweep: period 1..6, duty 0..period+1 (R4, R5, R6, R7, R1, R2, R3)
        for (int c = 1; c <= 6; c++) begin
            for (int d = 0; d <= c + 1; d++) begin
                stop_ch();
                wr(2'd3, 16'd1);
                rd(2'd3, v); chk(v == 16'd0, "R3 flag cleared", v, 0);
                wr(2'd0, 16'(c));
                wr(2'd1, 16'(d));
                start_ch();
                for (int k = 0; k < c; k++) tick("R7 hold after start");
                rd(2'd3, v); chk(v == 16'd0, "R3 no wrap yet", v, 0);
                tick(d == 0 ? "R4 zero duty" : (d >= c ? "R5 full duty" : "R6 duty compare"));
                rd(2'd3, v); chk(v == 16'd1, "R3 flag set at wrap", v, 1);
                for (int k = 0; k < 2 * c; k++)
                    tick(d == 0 ? "R4 zero duty" : (d >= c ? "R5 full duty" : "R6 duty compare"));
                rd(2'd3, v); chk(v == 16'd1, "R3 flag sticky", v, 1);
            end
        end

        // R2: staging write partway through a period
        stop_ch();
        wr(2'd0, 16'd4); wr(2'd1, 16'd1);
        start_ch();
        for (int k = 0; k < 6; k++) tick("R1 setup");
        wr(2'd1, 16'd3);
        for (int k = 0; k < 2; k++) tick("R2 old duty until wrap");
        for (int k = 0; k < 4; k++) tick("R2 new duty after wrap");

        // R8: stop freezes output and count; restart holds one period
        for (int k = 0; k < 2; k++) tick("R8 setup");
        stop_ch();
        for (int k = 0; k < 3; k++) tick("R8 frozen while stopped");
        wr(2'd1, 16'd0);
        start_ch();
        for (int k = 0; k < 4; k++) tick("R8 restart hold");
        for (int k = 0; k < 4; k++) tick("R8 restart from 1");

        // R9: clear and wrap in the same clock
        stop_ch();
        wr(2'd0, 16'd3); wr(2'd1, 16'd2);
        start_ch();
        for (int k = 0; k < 6; k++) tick("R9 setup");
        wr(2'd3, 16'd1);
        rd(2'd3, v); chk(v == 16'd0, "R9 pre-clear", v, 0);
        @(negedge clk);
        cnt_en = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'd1;
        @(negedge clk);
        cnt_en = 1'b0; wr_en = 1'b0;
        rd(2'd3, v); chk(v == 16'd1, "R9 wrap beats clear", v, 1);
        wr(2'd3, 16'd1);
        rd(2'd3, v); chk(v == 16'd0, "R3 clear works", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule